// File: doc/BRIEF.md
# Gated Serial Transmitter with Holding Queue

This block turns bytes written by a host into asynchronous serial frames. Each write lands in a 16-entry first-in first-out queue. A shift stage pulls characters from the queue one at a time. It frames each character with a start bit, 5 to 8 data bits, an optional parity bit and one or two stop bits, then drives the frame onto the serial line. Bit timing comes from an external enable pulse that runs at sixteen times the baud rate. Each bit is held for sixteen of these pulses.

A transceiver-enable input gates the transmitter. While it is low, written characters stay in the queue and the line stays idle. A loopback input sends the serial stream to a receive-side output and keeps the pin idle. Two status outputs are provided. One reports that the queue still has a free slot. The other reports that the queue and the shift stage are both empty.

Top module: `uart_tx_gated`

## Requirements
- R1: After reset, `txd` and `loop_rxd` are 1, and `thr_empty` and `tx_empty` are both 1.
- R2: A frame is one start bit (0), then the data bits LSB first, then the parity bit if enabled, then the stop bits (1). Each bit lasts exactly 16 cycles in which `tick16` is high.
- R3: `char_len` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data is taken from the low bits of the written byte, and the unused upper bits have no effect on the line.
- R4: When `parity_en` is 1, a parity bit follows the data. With `parity_odd` = 0, the data bits plus the parity bit hold an even number of ones. With `parity_odd` = 1, they hold an odd number.
- R5: `two_stop` = 0 sends one stop bit and `two_stop` = 1 sends two.
- R6: The serial line is 1 whenever no frame is in progress.
- R7: While `tx_enable` is 0, no new frame starts and queued characters are kept. When it is set, they are sent in order.
- R8: The queue holds 16 characters and sends them in write order. A write while 16 characters are queued is dropped.
- R9: `thr_empty` is 1 exactly when fewer than 16 characters are queued.
- R10: `tx_empty` is 1 only when the queue is empty and no frame is in progress.
- R11: When `loopback` is 1, the frame appears on `loop_rxd` and `txd` stays 1. When `loopback` is 0, `loop_rxd` stays 1.
- R12: A new character starts on the first `tick16` after the previous frame's last stop bit has ended. The line settings are captured when that character starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Enable pulse at 16x the baud rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to queue, right-justified |
| char_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Append a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| two_stop | input | 1 | 1 selects two stop bits |
| tx_enable | input | 1 | Transceiver enable; frames start only while it is 1 |
| loopback | input | 1 | Send the serial stream to `loop_rxd` instead of `txd` |
| txd | output | 1 | Serial output pin, idle high |
| loop_rxd | output | 1 | Looped-back serial stream, idle high |
| thr_empty | output | 1 | At least one queue slot is free |
| tx_empty | output | 1 | Queue empty and shifter idle |

## Verification
Every combination of character length, parity mode and stop count is tried. Each combination is sent with a byte that has its upper bits set and then with that byte's complement. This separates masking errors, bit-order errors and parity-sense errors. A queue-filling run with distinct bytes, sent while transmission is disabled, checks that order is kept, that the free-slot flag falls at the sixteenth write and that a seventeenth write is lost. Slowing the tick pulse to one in three cycles shows that bit timing follows the pulse count and not the clock. A loopback frame shows the diverted stream and an idle pin.

// File: rtl/uart_tx_gated.sv
module uart_tx_gated #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [1:0] char_len,
  input  logic       parity_en,
  input  logic       parity_odd,
  input  logic       two_stop,
  input  logic       tx_enable,
  input  logic       loopback,
  output logic       txd,
  output logic       loop_rxd,
  output logic       thr_empty,
  output logic       tx_empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int FW = 12;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [FW-1:0] sr, fr;
  logic [3:0]    tcnt, bcnt, nbits, nd;
  logic          par;

  wire full = (cnt == CW'(DEPTH));
  wire push = wr_en && !full;
  wire load = tick16 && !busy && tx_enable && (cnt != '0);
  wire line = busy ? sr[0] : 1'b1;

  assign txd       = loopback ? 1'b1 : line;
  assign loop_rxd  = loopback ? line : 1'b1;
  assign thr_empty = !full;
  assign tx_empty  = (cnt == '0) && !busy;

  always_ff @(posedge clk)
    if (push) mem[wp] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (load) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(load);
    end
  end

  always_comb begin
    nd  = 4'd5 + {2'b00, char_len};
    fr  = '1;
    fr[0] = 1'b0;
    par = parity_odd;
    for (int i = 0; i < 8; i++)
      if (i < int'(nd)) begin
        fr[1+i] = mem[rp][i];
        par     = par ^ mem[rp][i];
      end
    if (parity_en) fr[4'd1 + nd] = par;
    nbits = 4'd2 + nd + {3'b000, parity_en} + {3'b000, two_stop};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sr   <= '1;
      tcnt <= '0;
      bcnt <= '0;
    end else if (load) begin
      busy <= 1'b1;
      sr   <= fr;
      tcnt <= '0;
      bcnt <= nbits;
    end else if (busy && tick16) begin
      if (tcnt == 4'd15) begin
        tcnt <= '0;
        sr   <= {1'b1, sr[FW-1:1]};
        bcnt <= bcnt - 1'b1;
        if (bcnt == 4'd1) busy <= 1'b0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  // R11
  loopback_pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loopback |-> txd);

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !load |=> full && $stable(wp));

  // R7
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !tx_enable |=> !busy);

  // R10
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> thr_empty && txd && loop_rxd);

  // R2
  tick_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick16 |=> $stable(line));
endmodule

// File: tb/tb_uart_tx_gated.sv
module tb_uart_tx_gated;
  logic clk = 0, rst_n = 0, tick16 = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] char_len = 2'd3;
  logic parity_en = 0, parity_odd = 0, two_stop = 0, tx_enable = 1, loopback = 0;
  logic txd, loop_rxd, thr_empty, tx_empty;
  int compared = 0, mismatched = 0, tick_div = 1, phase = 0;
  bit loop_bad, pin_bad;

  always #2.5 clk = ~clk;

  uart_tx_gated dut (.clk, .rst_n, .tick16, .wr_en, .wr_data, .char_len, .parity_en,
    .parity_odd, .two_stop, .tx_enable, .loopback, .txd, .loop_rxd, .thr_empty, .tx_empty);

  always @(negedge clk) begin
    if (phase >= tick_div - 1) begin phase = 0; tick16 = 1; end
    else begin phase++; tick16 = 0; end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] expect_frame(logic [7:0] d, int len, bit pe, bit po,
                                               bit ts, output int nb);
    logic [11:0] f = '0;
    int n = len + 5;
    int ones = 0;
    for (int i = 0; i < n; i++) begin f[1+i] = d[i]; ones += d[i]; end
    nb = n + 2;
    if (pe) begin f[1+n] = ((ones % 2) == 1) ^ po; nb++; end
    f[nb-1] = 1'b1;
    if (ts) begin f[nb] = 1'b1; nb++; end
    return f;
  endfunction

  task automatic push(logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic receive(bit use_loop, int nb, output logic [11:0] bits, output bit found);
    int tc = 0, k = 0;
    bits = '0; found = 0;
    for (int i = 0; i < 20000 && !found; i++) begin
      @(negedge clk);
      if ((use_loop ? loop_rxd : txd) == 1'b0) found = 1;
    end
    if (!found) return;
    while (k < nb) begin
      if (use_loop && !txd) loop_bad = 1;
      if (!use_loop && !loop_rxd) pin_bad = 1;
      if (tick16) begin
        tc++;
        if (tc == 8 + 16 * k) begin bits[k] = use_loop ? loop_rxd : txd; k++; end
      end
      if (k < nb) @(negedge clk);
    end
  endtask

  task automatic quiet_window(int cycles, output bit low_seen);
    low_seen = 0;
    for (int i = 0; i < cycles; i++) begin @(negedge clk); if (!txd) low_seen = 1; end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [11:0] got, exp;
    int nb;
    bit found, low;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 txd", txd, 1);
    check("R1 loop_rxd", loop_rxd, 1);
    check("R1 thr_empty", thr_empty, 1);
    check("R1 tx_empty", tx_empty, 1);

    // R7: gating holds a queued character
    tx_enable = 0;
    push(8'h5A);
    quiet_window(400, low);
    check("R7 no frame while disabled", low, 0);
    check("R10 busy with queued char", tx_empty, 0);
    check("R9 space left", thr_empty, 1);
    tx_enable = 1;
    exp = expect_frame(8'h5A, 3, 0, 0, 0, nb);
    receive(0, nb, got, found);
    check("R7 frame after enable", {found, got}, {1'b1, exp});
    repeat (40) @(negedge clk);
    check("R10 empty after frame", tx_empty, 1);

    // R2 R3 R4 R5 sweep over every line setting
    for (int len = 0; len < 4; len++)
      for (int pm = 0; pm < 3; pm++)
        for (int st = 0; st < 2; st++)
          for (int v = 0; v < 2; v++) begin
            logic [7:0] d = 8'hE0 ^ 8'(len * 37 + pm * 11 + st * 5);
            if (v == 1) d = ~d;
            char_len = 2'(len); parity_en = (pm != 0); parity_odd = (pm == 2);
            two_stop = st[0];
            push(d);
            exp = expect_frame(d, len, pm != 0, pm == 2, st[0], nb);
            receive(0, nb, got, found);
            check("R2 R3 R4 R5 frame", {found, got}, {1'b1, exp});
            repeat (40) @(negedge clk);
          end
    check("R11 loop_rxd idle when not looping", pin_bad, 0);

    // R8 R9: fill queue while disabled
    char_len = 2'd3; parity_en = 0; two_stop = 0;
    tx_enable = 0;
    for (int i = 0; i < 16; i++) begin
      push(8'(i * 13 + 1));
      if (i == 14) check("R9 one slot left", thr_empty, 1);
    end
    check("R9 full flag", thr_empty, 0);
    push(8'hFF);
    check("R10 not empty while full", tx_empty, 0);
    tx_enable = 1;
    for (int i = 0; i < 16; i++) begin
      exp = expect_frame(8'(i * 13 + 1), 3, 0, 0, 0, nb);
      receive(0, nb, got, found);
      check("R8 order kept", {found, got}, {1'b1, exp});
    end
    quiet_window(400, low);
    check("R8 dropped write not sent", low, 0);
    check("R6 idle high", txd, 1);
    check("R10 drained", tx_empty, 1);

    // R11 loopback
    loopback = 1;
    push(8'h96);
    exp = expect_frame(8'h96, 3, 0, 0, 0, nb);
    receive(1, nb, got, found);
    check("R11 looped frame", {found, got}, {1'b1, exp});
    check("R11 pin idle", loop_bad, 0);
    repeat (40) @(negedge clk);
    loopback = 0;

    // R2 R12: slower tick and back-to-back frames
    tick_div = 3;
    tx_enable = 0;
    push(8'h3C);
    push(8'hC3);
    tx_enable = 1;
    exp = expect_frame(8'h3C, 3, 0, 0, 0, nb);
    receive(0, nb, got, found);
    check("R2 slow tick frame", {found, got}, {1'b1, exp});
    exp = expect_frame(8'hC3, 3, 0, 0, 0, nb);
    receive(0, nb, got, found);
    check("R12 second frame", {found, got}, {1'b1, exp});
    repeat (200) @(negedge clk);
    check("R6 idle after run", txd, 1);
    finish_run();
  end
endmodule